// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks a cache's outstanding misses in a small file of slots. Each slot holds a block-aligned address, an address-space id, an owning thread, an age stamp, a no-allocate flag, an uncacheable flag and a count of merged targets. When a cacheable miss arrives, it is compared in parallel against every occupied cacheable slot. If a slot matches, the miss merges into it as one more target. If none matches, the miss takes the lowest-numbered free slot. Uncacheable misses skip the compare and always take a fresh slot.

Each slot runs its own small state machine with three states: `SLOT_FREE`, `SLOT_PEND` (waiting for the bus) and `SLOT_BUSY` (sent to the bus). The transitions are:
- alloc: `SLOT_FREE` to `SLOT_PEND`.
- issue: `SLOT_PEND` to `SLOT_BUSY`, taking the slot shown on the issue port when `svc_valid` is high.
- squash: `SLOT_PEND` to `SLOT_FREE`, for pending slots owned by the squashed thread.
- retire: `SLOT_BUSY` to `SLOT_FREE`, on a response that serves all of the slot's targets.
- requeue: `SLOT_BUSY` to `SLOT_PEND`, on a response that leaves some targets.

The issue port shows the pending slot that goes to the bus next. Three registers drive the cache: `bus_req`, and two stall flags, one for "no free slot" and one for "target limit reached". The cache presents at most one event per cycle. If several arrive in the same cycle, squash wins, then response, then issue, then request.

Top module: `mshr_file`

## Requirements
- R1: After reset every slot is free: `iss_valid`, `bus_req`, `blocked_nomshr` and `blocked_notgt` are all 0.
- R2: A request address is aligned by clearing its low log2(BLK_BYTES) bits. Two cacheable requests in the same block with the same address-space id merge: `iss_ntgt` rises by one and `iss_addr` shows the aligned address.
- R3: A cacheable request matches a slot only when both the aligned address and the address-space id are equal. Otherwise it allocates a new slot.
- R4: An uncacheable request always allocates a new slot, even when its address matches. No later cacheable request merges into an uncacheable slot.
- R5: When a request from a different thread merges into a slot, the slot's thread field becomes all ones, meaning shared.
- R6: A merge from a request without no-allocate clears the slot's no-allocate flag. A merge from a no-allocate request leaves the flag set.
- R7: A merge that brings a slot's target count to NUM_TARGETS raises `blocked_notgt`. That slot is then issued ahead of older pending slots. Further merges into it are ignored, so its count stays at NUM_TARGETS. A response to that slot, or a squash of its owning thread, clears `blocked_notgt`.
- R8: Allocation takes the lowest-numbered free slot. Taking the last free slot raises `blocked_nomshr`, which falls when a slot is freed by a retiring response or a squash.
- R9: Among pending slots, with no target-limit slot pending, the slot with the oldest age stamp is issued first. Every allocation takes the next stamp from one counter.
- R10: A response whose served count is below the slot's target count subtracts the served count from the target count. It returns the slot to pending with a fresh stamp, so the slot is issued after slots that were already waiting. A response serving all targets frees the slot.
- R11: An allocation with `req_hwpf` high does not raise `bus_req`. Every other allocation and every requeue raises it. `bus_req` falls once no slot is pending.
- R12: A squash frees only the pending slots whose thread field equals `squash_thread`. Slots that are being served stay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New miss this cycle |
| req_addr | input | ADDR_W | Miss byte address |
| req_asid | input | ASID_W | Address-space id |
| req_thread | input | THR_W | Requesting thread |
| req_uncache | input | 1 | Miss is uncacheable |
| req_noalloc | input | 1 | Miss must not allocate in the cache |
| req_hwpf | input | 1 | Miss comes from the hardware prefetcher |
| svc_valid | input | 1 | Slot on the issue port is sent to the bus |
| rsp_valid | input | 1 | Fill response arrives |
| rsp_idx | input | IDX_W | Slot the response belongs to |
| rsp_served | input | TGT_W | Number of targets the response served |
| squash_valid | input | 1 | Squash a thread |
| squash_thread | input | THR_W | Thread to squash |
| iss_valid | output | 1 | Some slot is pending |
| iss_idx | output | IDX_W | Slot to issue next |
| iss_addr | output | ADDR_W | Aligned address of that slot |
| iss_thread | output | THR_W | Thread field of that slot (all ones means shared) |
| iss_noalloc | output | 1 | No-allocate flag of that slot |
| iss_ntgt | output | TGT_W | Target count of that slot |
| bus_req | output | 1 | Bus request to the cache |
| blocked_nomshr | output | 1 | Stall: no free slot |
| blocked_notgt | output | 1 | Stall: a slot reached the target limit |

## Verification
The bench targets these corner cases, and the failure each one would expose:
- Offsets inside one block must merge rather than allocate. A design that compared full addresses would allocate instead.
- An equal address with a different address-space id, or an uncacheable request at a live address, must allocate. A design that ignored the id or the uncacheable flag would merge instead.
- A full target list must be issued first and must refuse a fifth merge. A design that got this wrong would issue by age and let the count overflow.
- A partial response must requeue behind waiting slots and re-raise the bus request. A design that got this wrong would issue the slot again at once, or leave the bus request low.
- A squash must spare in-service slots yet clear the target stall of its thread. A design that got this wrong would drop in-flight slots, or stay stalled forever.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_PEND = 2'd1,
        SLOT_BUSY = 2'd2
    } slot_st_e;
endpackage

// File: rtl/mshr_lowest.sv
// Finds the lowest set bit of a vector.
module mshr_lowest #(
    parameter int N    = 4,
    parameter int IW   = 2
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/mshr_match.sv
// Parallel compare of a query block address and id against every slot.
module mshr_match #(
    parameter int N      = 4,
    parameter int IW     = 2,
    parameter int TAG_W  = 32,
    parameter int ASID_W = 8
) (
    input  logic [N-1:0]             cand,
    input  logic [N-1:0][TAG_W-1:0]  tags,
    input  logic [N-1:0][ASID_W-1:0] ids,
    input  logic [TAG_W-1:0]         q_tag,
    input  logic [ASID_W-1:0]        q_id,
    output logic                     hit,
    output logic [IW-1:0]            hit_idx
);
    logic [N-1:0] hit_vec;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = cand[i] && (tags[i] == q_tag) && (ids[i] == q_id);
    end

    mshr_lowest #(.N(N), .IW(IW)) u_enc (
        .vec   (hit_vec),
        .found (hit),
        .idx   (hit_idx)
    );
endmodule

// File: rtl/mshr_oldest.sv
// Selects the pending slot with the smallest age stamp.
module mshr_oldest #(
    parameter int N     = 4,
    parameter int IW    = 2,
    parameter int ORD_W = 8
) (
    input  logic [N-1:0]            pend,
    input  logic [N-1:0][ORD_W-1:0] stamps,
    output logic                    found,
    output logic [IW-1:0]           idx
);
    logic [ORD_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && (!found || stamps[i] < best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = stamps[i];
            end
        end
    end
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
    parameter int NUM_ENTRIES = 4,
    parameter int NUM_TARGETS = 4,
    parameter int ADDR_W      = 32,
    parameter int BLK_BYTES   = 64,
    parameter int ASID_W      = 8,
    parameter int THR_W       = 2,
    parameter int ORD_W       = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int TGT_W      = $clog2(NUM_TARGETS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [THR_W-1:0]  req_thread,
    input  logic              req_uncache,
    input  logic              req_noalloc,
    input  logic              req_hwpf,
    input  logic              svc_valid,
    input  logic              rsp_valid,
    input  logic [IDX_W-1:0]  rsp_idx,
    input  logic [TGT_W-1:0]  rsp_served,
    input  logic              squash_valid,
    input  logic [THR_W-1:0]  squash_thread,
    output logic              iss_valid,
    output logic [IDX_W-1:0]  iss_idx,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [THR_W-1:0]  iss_thread,
    output logic              iss_noalloc,
    output logic [TGT_W-1:0]  iss_ntgt,
    output logic              bus_req,
    output logic              blocked_nomshr,
    output logic              blocked_notgt
);
    import mshr_pkg::*;

    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLK_BYTES - 1);
    localparam logic [TGT_W-1:0]  TGT_MAX  = TGT_W'(NUM_TARGETS);

    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] tag_all;
    logic [NUM_ENTRIES-1:0][ASID_W-1:0] asid_all;
    logic [NUM_ENTRIES-1:0][THR_W-1:0]  thr_all;
    logic [NUM_ENTRIES-1:0][ORD_W-1:0]  ord_all;
    logic [NUM_ENTRIES-1:0][TGT_W-1:0]  ntgt_all;
    logic [NUM_ENTRIES-1:0]             noal_all, free_v, pend_v, cand_v, sq_v, pend_nx;

    logic [ADDR_W-1:0] blk_addr;
    logic              hit, has_free, has_old;
    logic [IDX_W-1:0]  hit_idx, free_idx, old_idx, notgt_idx;
    logic [ORD_W-1:0]  ord_ctr;
    logic              ev_sq, ev_rsp, ev_svc, ev_req;
    logic              do_merge, do_alloc, rsp_retire, rsp_part, last_free, urgent;

    assign blk_addr = req_addr & ~OFF_MASK;

    mshr_match #(.N(NUM_ENTRIES), .IW(IDX_W), .TAG_W(ADDR_W), .ASID_W(ASID_W)) u_match (
        .cand    (cand_v),
        .tags    (tag_all),
        .ids     (asid_all),
        .q_tag   (blk_addr),
        .q_id    (req_asid),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    mshr_lowest #(.N(NUM_ENTRIES), .IW(IDX_W)) u_free (
        .vec   (free_v),
        .found (has_free),
        .idx   (free_idx)
    );

    mshr_oldest #(.N(NUM_ENTRIES), .IW(IDX_W), .ORD_W(ORD_W)) u_age (
        .pend   (pend_v),
        .stamps (ord_all),
        .found  (has_old),
        .idx    (old_idx)
    );

    // one event per cycle: squash > response > issue > request
    always_comb begin
        ev_sq      = squash_valid;
        ev_rsp     = !ev_sq && rsp_valid && (ntgt_all[rsp_idx] != '0) && !pend_v[rsp_idx] && !free_v[rsp_idx];
        ev_svc     = !ev_sq && !rsp_valid && svc_valid && has_old;
        ev_req     = !ev_sq && !rsp_valid && !svc_valid && req_valid;
        do_merge   = ev_req && !req_uncache && hit && (ntgt_all[hit_idx] < TGT_MAX);
        do_alloc   = ev_req && (req_uncache || !hit) && has_free;
        rsp_retire = ev_rsp && (rsp_served >= ntgt_all[rsp_idx]);
        rsp_part   = ev_rsp && !rsp_retire;
        last_free  = has_free && ((free_v & (free_v - 1'b1)) == '0);
        urgent     = blocked_notgt && pend_v[notgt_idx];
    end

    assign iss_valid   = has_old;
    assign iss_idx     = urgent ? notgt_idx : old_idx;
    assign iss_addr    = tag_all[iss_idx];
    assign iss_thread  = thr_all[iss_idx];
    assign iss_noalloc = noal_all[iss_idx];
    assign iss_ntgt    = ntgt_all[iss_idx];

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
        slot_st_e          st_q, st_d;
        logic [ADDR_W-1:0] tag_q;
        logic [ASID_W-1:0] asid_q;
        logic [THR_W-1:0]  thr_q;
        logic [ORD_W-1:0]  ord_q;
        logic [TGT_W-1:0]  ntgt_q;
        logic              noal_q, uc_q;
        logic              alloc_me, merge_me, part_me;

        assign alloc_me = do_alloc && (free_idx == IDX_W'(i));
        assign merge_me = do_merge && (hit_idx == IDX_W'(i));
        assign part_me  = rsp_part && (rsp_idx == IDX_W'(i));

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                SLOT_FREE: if (alloc_me) st_d = SLOT_PEND;
                SLOT_PEND: begin
                    if (ev_sq && sq_v[i])                        st_d = SLOT_FREE;
                    else if (ev_svc && iss_idx == IDX_W'(i))     st_d = SLOT_BUSY;
                end
                SLOT_BUSY: if (ev_rsp && rsp_idx == IDX_W'(i))
                               st_d = rsp_retire ? SLOT_FREE : SLOT_PEND;
                default:   st_d = SLOT_FREE;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= SLOT_FREE;
            else        st_q <= st_d;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q  <= '0;
                asid_q <= '0;
                thr_q  <= '0;
                ord_q  <= '0;
                ntgt_q <= '0;
                noal_q <= 1'b0;
                uc_q   <= 1'b0;
            end else if (alloc_me) begin
                tag_q  <= blk_addr;
                asid_q <= req_asid;
                thr_q  <= req_thread;
                ord_q  <= ord_ctr;
                ntgt_q <= TGT_W'(1);
                noal_q <= req_noalloc;
                uc_q   <= req_uncache;
            end else if (merge_me) begin
                ntgt_q <= ntgt_q + 1'b1;
                if (thr_q != req_thread) thr_q <= '1;
                if (!req_noalloc)        noal_q <= 1'b0;
            end else if (part_me) begin
                ord_q  <= ord_ctr;
                ntgt_q <= ntgt_q - rsp_served;
            end else if (st_d == SLOT_FREE) begin
                ntgt_q <= '0;
            end
        end

        assign free_v[i]   = (st_q == SLOT_FREE);
        assign pend_v[i]   = (st_q == SLOT_PEND);
        assign cand_v[i]   = (st_q != SLOT_FREE) && !uc_q;
        assign sq_v[i]     = (st_q == SLOT_PEND) && (thr_q == squash_thread);
        assign pend_nx[i]  = (st_d == SLOT_PEND);
        assign tag_all[i]  = tag_q;
        assign asid_all[i] = asid_q;
        assign thr_all[i]  = thr_q;
        assign ord_all[i]  = ord_q;
        assign ntgt_all[i] = ntgt_q;
        assign noal_all[i] = noal_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ord_ctr        <= '0;
            bus_req        <= 1'b0;
            blocked_nomshr <= 1'b0;
            blocked_notgt  <= 1'b0;
            notgt_idx      <= '0;
        end else begin
            if (do_alloc || rsp_part) ord_ctr <= ord_ctr + 1'b1;

            if ((do_alloc && !req_hwpf) || rsp_part) bus_req <= 1'b1;
            else if (!(|pend_nx))                    bus_req <= 1'b0;

            if (do_alloc && last_free)                   blocked_nomshr <= 1'b1;
            else if (rsp_retire || (ev_sq && (|sq_v)))   blocked_nomshr <= 1'b0;

            if (do_merge && ntgt_all[hit_idx] == TGT_MAX - 1'b1) begin
                blocked_notgt <= 1'b1;
                notgt_idx     <= hit_idx;
            end else if ((ev_rsp && rsp_idx == notgt_idx) ||
                         (ev_sq && thr_all[notgt_idx] == squash_thread)) begin
                blocked_notgt <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
    parameter int NUM_ENTRIES = 4,
    parameter int NUM_TARGETS = 4,
    parameter int THR_W       = 2,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int TGT_W      = $clog2(NUM_TARGETS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_uncache,
    input logic             req_hwpf,
    input logic             rsp_valid,
    input logic             squash_valid,
    input logic             iss_valid,
    input logic [IDX_W-1:0] iss_idx,
    input logic [THR_W-1:0] iss_thread,
    input logic [TGT_W-1:0] iss_ntgt,
    input logic             bus_req,
    input logic             blocked_nomshr,
    input logic             blocked_notgt
);
    p_ntgt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_ntgt != '0) && (iss_ntgt <= TGT_W'(NUM_TARGETS)));

    p_notgt_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blocked_notgt) |-> $past(req_valid && !req_uncache));

    p_nomshr_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blocked_nomshr) |-> $past(req_valid));

    p_nomshr_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blocked_nomshr) |-> $past(rsp_valid || squash_valid));

    p_busreq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past((req_valid && !req_hwpf) || rsp_valid));

    p_shared_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && $past(iss_valid) && iss_idx == $past(iss_idx) &&
         $past(iss_thread) == '1 && !$past(rsp_valid || squash_valid))
        |-> iss_thread == '1);
endmodule

bind mshr_file mshr_file_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_TARGETS (NUM_TARGETS),
    .THR_W       (THR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_uncache    (req_uncache),
    .req_hwpf       (req_hwpf),
    .rsp_valid      (rsp_valid),
    .squash_valid   (squash_valid),
    .iss_valid      (iss_valid),
    .iss_idx        (iss_idx),
    .iss_thread     (iss_thread),
    .iss_ntgt       (iss_ntgt),
    .bus_req        (bus_req),
    .blocked_nomshr (blocked_nomshr),
    .blocked_notgt  (blocked_notgt)
);

// File: tb/sim_mshr_file.sv
module sim_mshr_file;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_uncache, req_noalloc, req_hwpf;
    logic [31:0] req_addr;
    logic [7:0]  req_asid;
    logic [1:0]  req_thread, squash_thread;
    logic        svc_valid, rsp_valid, squash_valid;
    logic [1:0]  rsp_idx;
    logic [2:0]  rsp_served;
    logic        iss_valid, iss_noalloc, bus_req, blocked_nomshr, blocked_notgt;
    logic [1:0]  iss_idx, iss_thread;
    logic [31:0] iss_addr;
    logic [2:0]  iss_ntgt;

    int n_checks = 0;
    int n_fail   = 0;

    // table: address, id, uncacheable, expected issue slot, expected count, expected no-slot stall
    localparam logic [31:0] V_ADDR [NV] = '{32'h1000, 32'h103F, 32'h1010, 32'h1000, 32'h1040};
    localparam logic [7:0]  V_ASID [NV] = '{8'd1, 8'd1, 8'd2, 8'd1, 8'd1};
    localparam logic        V_UC   [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic [1:0]  V_IDX  [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
    localparam logic [2:0]  V_NT   [NV] = '{3'd1, 3'd2, 3'd2, 3'd2, 3'd2};
    localparam logic        V_FULL [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    mshr_file u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_asid(req_asid),
        .req_thread(req_thread), .req_uncache(req_uncache), .req_noalloc(req_noalloc),
        .req_hwpf(req_hwpf), .svc_valid(svc_valid), .rsp_valid(rsp_valid),
        .rsp_idx(rsp_idx), .rsp_served(rsp_served), .squash_valid(squash_valid),
        .squash_thread(squash_thread), .iss_valid(iss_valid), .iss_idx(iss_idx),
        .iss_addr(iss_addr), .iss_thread(iss_thread), .iss_noalloc(iss_noalloc),
        .iss_ntgt(iss_ntgt), .bus_req(bus_req), .blocked_nomshr(blocked_nomshr),
        .blocked_notgt(blocked_notgt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_addr = '0; req_asid = '0; req_thread = '0;
        req_uncache = 0; req_noalloc = 0; req_hwpf = 0;
        svc_valid = 0; rsp_valid = 0; rsp_idx = '0; rsp_served = '0;
        squash_valid = 0; squash_thread = '0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1 idle();
    endtask

    task automatic req(input logic [31:0] a, input logic [7:0] id, input logic [1:0] t,
                       input logic uc, input logic na, input logic hw);
        req_valid = 1; req_addr = a; req_asid = id; req_thread = t;
        req_uncache = uc; req_noalloc = na; req_hwpf = hw;
        tick();
    endtask

    task automatic svc();
        svc_valid = 1;
        tick();
    endtask

    task automatic rsp(input logic [1:0] i, input logic [2:0] n);
        rsp_valid = 1; rsp_idx = i; rsp_served = n;
        tick();
    endtask

    task automatic squash(input logic [1:0] t);
        squash_valid = 1; squash_thread = t;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 iss_valid", 32'(iss_valid), 0);
        check("R1 bus_req", 32'(bus_req), 0);
        check("R1 nomshr", 32'(blocked_nomshr), 0);
        check("R1 notgt", 32'(blocked_notgt), 0);

        // table: R2 alignment merge, R3 id mismatch, R4 uncacheable, R8 last slot
        for (int k = 0; k < NV; k++) begin
            req(V_ADDR[k], V_ASID[k], 2'd0, V_UC[k], 1'b0, 1'b0);
            check($sformatf("R2/R3/R4 vec%0d idx", k), 32'(iss_idx), 32'(V_IDX[k]));
            check($sformatf("R2/R3/R4 vec%0d ntgt", k), 32'(iss_ntgt), 32'(V_NT[k]));
            check($sformatf("R8 vec%0d nomshr", k), 32'(blocked_nomshr), 32'(V_FULL[k]));
        end
        check("R2 aligned addr", iss_addr, 32'h1000);

        svc();
        check("R9 oldest next", 32'(iss_idx), 1);
        check("R3 new slot count", 32'(iss_ntgt), 1);
        rsp(2'd0, 3'd1);                         // partial: R10
        check("R10 requeue stays behind", 32'(iss_idx), 1);
        svc();
        check("R4 uncache slot", 32'(iss_idx), 2);
        check("R4 uncache not merged", 32'(iss_ntgt), 1);
        svc();
        check("R9 slot3 next", 32'(iss_idx), 3);
        svc();
        check("R10 requeued slot last", 32'(iss_idx), 0);
        check("R10 count reduced", 32'(iss_ntgt), 1);
        check("R10 bus_req raised", 32'(bus_req), 1);
        svc();
        check("R11 no pending valid", 32'(iss_valid), 0);
        check("R11 bus_req drops", 32'(bus_req), 0);
        rsp(2'd1, 3'd1);
        check("R8 stall released", 32'(blocked_nomshr), 0);
        req(32'h3000, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R8 lowest free slot", 32'(iss_idx), 1);
        check("R11 bus_req on alloc", 32'(bus_req), 1);

        // R5 / R6
        do_reset();
        req(32'h4000, 8'd3, 2'd0, 1'b0, 1'b1, 1'b0);
        req(32'h4008, 8'd3, 2'd0, 1'b0, 1'b1, 1'b0);
        check("R6 noalloc kept", 32'(iss_noalloc), 1);
        check("R5 same thread kept", 32'(iss_thread), 0);
        req(32'h4010, 8'd3, 2'd1, 1'b0, 1'b0, 1'b0);
        check("R6 noalloc cleared", 32'(iss_noalloc), 0);
        check("R5 shared thread", 32'(iss_thread), 3);
        check("R5 count", 32'(iss_ntgt), 3);

        // R7
        do_reset();
        req(32'h5000, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        req(32'h6000, 8'd0, 2'd1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) req(32'h6004, 8'd0, 2'd1, 1'b0, 1'b0, 1'b0);
        check("R7 notgt raised", 32'(blocked_notgt), 1);
        check("R7 full slot first", 32'(iss_idx), 1);
        req(32'h6004, 8'd0, 2'd1, 1'b0, 1'b0, 1'b0);
        check("R7 extra merge ignored", 32'(iss_ntgt), 4);
        svc();
        check("R7 older next", 32'(iss_idx), 0);
        rsp(2'd1, 3'd1);
        check("R7 notgt cleared by response", 32'(blocked_notgt), 0);
        svc();
        check("R10 partial count", 32'(iss_ntgt), 3);

        // R11 prefetch
        do_reset();
        req(32'h7000, 8'd0, 2'd0, 1'b0, 1'b0, 1'b1);
        check("R11 prefetch pending", 32'(iss_valid), 1);
        check("R11 prefetch no bus_req", 32'(bus_req), 0);
        req(32'h7100, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R11 demand bus_req", 32'(bus_req), 1);

        // R12
        do_reset();
        req(32'h8000, 8'd0, 2'd1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) req(32'h8000, 8'd0, 2'd1, 1'b0, 1'b0, 1'b0);
        req(32'h9000, 8'd0, 2'd2, 1'b0, 1'b0, 1'b0);
        req(32'hA000, 8'd0, 2'd1, 1'b0, 1'b0, 1'b0);
        req(32'hB000, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R12 setup full", 32'(blocked_nomshr), 1);
        svc();
        squash(2'd1);
        check("R12 notgt cleared", 32'(blocked_notgt), 0);
        check("R12 nomshr cleared", 32'(blocked_nomshr), 0);
        check("R12 other thread next", 32'(iss_idx), 1);
        squash(2'd2);
        check("R12 thread2 gone", 32'(iss_idx), 3);
        squash(2'd0);
        check("R12 none pending", 32'(iss_valid), 0);
        check("R11 bus_req after squash", 32'(bus_req), 0);
        rsp(2'd0, 3'd4);
        req(32'hC000, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R12 busy slot survived", 32'(iss_idx), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule